// File: doc/BRIEF.md
# Multiplexed General-Purpose Pin Port

This block manages a bank of sixteen pads. Each pad is in one of two modes. In software mode it has an output latch, a direction bit and an input-buffer gate. In peripheral mode the pad is handed to one of four peripheral functions, and a two-bit selector per pad picks which one. The peripheral's output and output-enable then reach the pad unchanged.

Software reaches the block through a small word-wide register bus. Writes take effect at the next clock edge. Reads return data one cycle after the read strobe. Direction and the output latch each have a pair of write-one-to-set and write-one-to-clear locations, so a driver can change single bits without a read-modify-write. Pad inputs pass through a two-stage synchroniser and are then gated by the input enable. The gated result goes both to the data read path and to a neighbouring pin-interrupt block.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is asserted and right after it, every register is zero. This means all pads are software-mode inputs with input buffers off: pad_oe, pad_out, irq_pins and bus_rdata are all zero.
- R2: A pad whose function-enable bit is 0 drives pad_oe from its direction bit and pad_out from its output latch bit.
- R3: The function-enable register sits at bus offset 0 and is read/write, one bit per pad. A pad whose bit is 1 takes pad_out and pad_oe from peripheral f, where f is its selector. It reads bit f*16+p of per_out and per_oe.
- R4: The selector register sits at offset 1 and is 32 bits, read/write. Pad p's selector is bits [2p+1:2p].
- R5: Writing offset 5 sets every direction bit where the write data is 1. Writing offset 6 clears every direction bit where the write data is 1. Zero data bits leave their bits unchanged. A read at either offset returns the direction register, where 1 means output.
- R6: Writing offset 3 sets bits of the output latch wherever the write data is 1. Writing offset 4 clears bits wherever the write data is 1. A read at either offset returns the latch.
- R7: A write to offset 2 overwrites the output latch. A read at offset 2 returns the latch bit for pads with direction 1. For pads with direction 0 it returns the synchronised pad input ANDed with the input enable.
- R8: The input-enable register sits at offset 7 and is read/write. A pad whose enable is 0 reads as 0 at offset 2 and shows 0 on irq_pins.
- R9: A change on pad_in appears on irq_pins two clock edges later, through exactly two synchroniser stages.
- R10: bus_rdata is loaded at the edge where bus_ren is high, with the value the registers held before any write in that same cycle. Otherwise bus_rdata holds its value. Offsets 8 to 15 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Register read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_ren |
| pad_in | input | 16 | Raw pad input levels |
| pad_oe | output | 16 | Pad output enable |
| pad_out | output | 16 | Pad output level |
| per_out | input | 64 | Peripheral output levels, function f at bits f*16+p |
| per_oe | input | 64 | Peripheral output enables, same layout |
| irq_pins | output | 16 | Synchronised, enable-gated pad inputs for the interrupt block |

## Verification
The hardest case is a mixed port. Some pads are in peripheral mode with different selectors, others are software outputs, and the rest are gated or ungated inputs. On top of that, register writes and pad toggles land in the same cycles as reads. To reach it, directed writes first build a port with all four selectors and every mode combination present. After that, a long stretch of random bus traffic, pad levels and peripheral buses runs against a cycle-level model. The model covers same-cycle write-and-read and the synchroniser delay.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    // number of address bits that decode a register; offsets above are unmapped
    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        A_FUNC = 3'd0,  // function enable per pad
        A_MUX  = 3'd1,  // peripheral selectors
        A_DATA = 3'd2,  // output latch write / pin state read
        A_DSET = 3'd3,  // latch write-one-to-set
        A_DCLR = 3'd4,  // latch write-one-to-clear
        A_DIRS = 3'd5,  // direction write-one-to-set
        A_DIRC = 3'd6,  // direction write-one-to-clear
        A_INEN = 3'd7   // input buffer enable
    } reg_addr_e;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mux_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int SELW = 2,
    parameter int AW   = 4,
    parameter int DW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wen,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_ren,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NPIN-1:0]      pin_sync,
    output logic [NPIN-1:0]      fer,
    output logic [NPIN*SELW-1:0] mux,
    output logic [NPIN-1:0]      dir,
    output logic [NPIN-1:0]      dout,
    output logic [NPIN-1:0]      inen
);

    localparam int MUXW = NPIN * SELW;

    typedef struct packed {
        logic [NPIN-1:0] fer;
        logic [MUXW-1:0] mux;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] inen;
        logic [DW-1:0]   rdata;
    } regs_t;

    regs_t     r_q, r_d;
    logic      hit_d;
    reg_addr_e sel_d;
    logic [NPIN-1:0] pin_view_d;

    always_comb begin
        r_d        = r_q;
        hit_d      = (bus_addr >> REG_IDX_W) == '0;
        sel_d      = reg_addr_e'(bus_addr[REG_IDX_W-1:0]);
        // driven pads report the latch, others report the gated input
        pin_view_d = (r_q.dout & r_q.dir) | (pin_sync & r_q.inen & ~r_q.dir);

        // read uses the state before this cycle's write
        if (bus_ren) begin
            r_d.rdata = '0;
            if (hit_d) begin
                case (sel_d)
                    A_FUNC:         r_d.rdata = DW'(r_q.fer);
                    A_MUX:          r_d.rdata = DW'(r_q.mux);
                    A_DATA:         r_d.rdata = DW'(pin_view_d);
                    A_DSET, A_DCLR: r_d.rdata = DW'(r_q.dout);
                    A_DIRS, A_DIRC: r_d.rdata = DW'(r_q.dir);
                    A_INEN:         r_d.rdata = DW'(r_q.inen);
                    default:        r_d.rdata = '0;
                endcase
            end
        end

        if (bus_wen && hit_d) begin
            case (sel_d)
                A_FUNC:  r_d.fer  = bus_wdata[NPIN-1:0];
                A_MUX:   r_d.mux  = bus_wdata[MUXW-1:0];
                A_DATA:  r_d.dout = bus_wdata[NPIN-1:0];
                A_DSET:  r_d.dout = r_q.dout | bus_wdata[NPIN-1:0];
                A_DCLR:  r_d.dout = r_q.dout & ~bus_wdata[NPIN-1:0];
                A_DIRS:  r_d.dir  = r_q.dir | bus_wdata[NPIN-1:0];
                A_DIRC:  r_d.dir  = r_q.dir & ~bus_wdata[NPIN-1:0];
                A_INEN:  r_d.inen = bus_wdata[NPIN-1:0];
                default: r_d.inen = r_q.inen;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;
    assign fer       = r_q.fer;
    assign mux       = r_q.mux;
    assign dir       = r_q.dir;
    assign dout      = r_q.dout;
    assign inen      = r_q.inen;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = raw;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync = s_q.s2;

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NPIN = 16,
    parameter int SELW = 2
) (
    input  logic [NPIN-1:0]               fer,
    input  logic [NPIN*SELW-1:0]          mux,
    input  logic [NPIN-1:0]               dir,
    input  logic [NPIN-1:0]               dout,
    input  logic [(NPIN<<SELW)-1:0]       per_out,
    input  logic [(NPIN<<SELW)-1:0]       per_oe,
    output logic [NPIN-1:0]               pad_oe,
    output logic [NPIN-1:0]               pad_out
);

    localparam int NFUNC = 1 << SELW;

    for (genvar p = 0; p < NPIN; p++) begin : g_pad
        logic [NFUNC-1:0] cand_o;
        logic [NFUNC-1:0] cand_e;
        logic [SELW-1:0]  fsel;
        logic             oe_b;
        logic             out_b;

        for (genvar f = 0; f < NFUNC; f++) begin : g_fn
            assign cand_o[f] = per_out[f*NPIN + p];
            assign cand_e[f] = per_oe[f*NPIN + p];
        end

        always_comb begin
            fsel = mux[p*SELW +: SELW];
            if (fer[p]) begin
                oe_b  = cand_e[fsel];
                out_b = cand_o[fsel];
            end else begin
                oe_b  = dir[p];
                out_b = dout[p];
            end
        end

        assign pad_oe[p]  = oe_b;
        assign pad_out[p] = out_b;
    end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
    parameter int NPIN = 16,
    parameter int SELW = 2,
    parameter int AW   = 4,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wen,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    input  logic                     bus_ren,
    output logic [DW-1:0]            bus_rdata,
    input  logic [NPIN-1:0]          pad_in,
    output logic [NPIN-1:0]          pad_oe,
    output logic [NPIN-1:0]          pad_out,
    input  logic [(NPIN<<SELW)-1:0]  per_out,
    input  logic [(NPIN<<SELW)-1:0]  per_oe,
    output logic [NPIN-1:0]          irq_pins
);

    localparam int MUXW = NPIN * SELW;

    logic [NPIN-1:0] fer_w;
    logic [MUXW-1:0] mux_w;
    logic [NPIN-1:0] dir_w;
    logic [NPIN-1:0] dout_w;
    logic [NPIN-1:0] inen_w;
    logic [NPIN-1:0] sync_w;

    gpio_in_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pad_in),
        .sync  (sync_w)
    );

    gpio_regs #(.NPIN(NPIN), .SELW(SELW), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ren   (bus_ren),
        .bus_rdata (bus_rdata),
        .pin_sync  (sync_w),
        .fer       (fer_w),
        .mux       (mux_w),
        .dir       (dir_w),
        .dout      (dout_w),
        .inen      (inen_w)
    );

    gpio_pad_mux #(.NPIN(NPIN), .SELW(SELW)) u_pads (
        .fer     (fer_w),
        .mux     (mux_w),
        .dir     (dir_w),
        .dout    (dout_w),
        .per_out (per_out),
        .per_oe  (per_oe),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    // gated inputs toward the pin-interrupt block
    assign irq_pins = sync_w & inen_w;

endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk
    import gpio_mux_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int AW   = 4,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wen,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic            bus_ren,
    input logic [DW-1:0]   bus_rdata,
    input logic [NPIN-1:0] pad_in,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] irq_pins,
    input logic [NPIN-1:0] fer,
    input logic [NPIN-1:0] dir,
    input logic [NPIN-1:0] dout,
    input logic [NPIN-1:0] inen
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assert_gpio_pad_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ dir) & ~fer) == '0);

    assert_dir_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == AW'(A_DIRS)) |=>
            ((dir & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

    assert_latch_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == AW'(A_DCLR)) |=>
            ((dout & $past(bus_wdata[NPIN-1:0])) == '0));

    assert_inen_gates_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pins & ~inen) == '0);

    assert_two_stage_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (irq_pins == ($past(pad_in, 2) & inen)));

    assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ren |=> $stable(bus_rdata));

endmodule

bind gpio_mux_port gpio_mux_port_chk #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ren   (bus_ren),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .irq_pins  (irq_pins),
    .fer       (fer_w),
    .dir       (dir_w),
    .dout      (dout_w),
    .inen      (inen_w)
);

// File: tb/tb_gpio_mux_port.sv
`timescale 1ns/1ps
module tb_gpio_mux_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ren = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_oe;
    logic [15:0] pad_out;
    logic [63:0] per_out = '0;
    logic [63:0] per_oe = '0;
    logic [15:0] irq_pins;

    always #2.5 clk = ~clk;

    gpio_mux_port dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .per_out(per_out), .per_oe(per_oe), .irq_pins(irq_pins)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    logic [15:0] m_fer, m_dir, m_dout, m_inen, m_s1, m_s2;
    logic [31:0] m_mux, m_rd;
    int          last_ra = 0;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string tag_of(int a);
        case (a)
            0: return "R3";
            1: return "R4";
            2: return "R7";
            3, 4: return "R6";
            5, 6: return "R5";
            7: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] ref_read(int a);
        case (a)
            0: return {16'h0, m_fer};
            1: return m_mux;
            2: return {16'h0, (m_dout & m_dir) | (m_s2 & m_inen & ~m_dir)};
            3, 4: return {16'h0, m_dout};
            5, 6: return {16'h0, m_dir};
            7: return {16'h0, m_inen};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_fer <= '0; m_dir <= '0; m_dout <= '0; m_inen <= '0;
            m_s1 <= '0; m_s2 <= '0; m_mux <= '0; m_rd <= '0;
        end else begin
            cycles <= cycles + 1;
            if (bus_ren) begin
                m_rd    <= ref_read(int'(bus_addr));
                last_ra <= int'(bus_addr);
            end
            if (bus_wen) begin
                case (int'(bus_addr))
                    0: m_fer  <= bus_wdata[15:0];
                    1: m_mux  <= bus_wdata;
                    2: m_dout <= bus_wdata[15:0];
                    3: m_dout <= m_dout | bus_wdata[15:0];
                    4: m_dout <= m_dout & ~bus_wdata[15:0];
                    5: m_dir  <= m_dir | bus_wdata[15:0];
                    6: m_dir  <= m_dir & ~bus_wdata[15:0];
                    7: m_inen <= bus_wdata[15:0];
                    default: ;
                endcase
            end
            m_s1 <= pad_in;
            m_s2 <= m_s1;
        end
    end

    // compare every cycle, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [15:0] e_oe, e_out;
            for (int p = 0; p < 16; p++) begin
                int f;
                f = int'(m_mux[2*p +: 2]);
                if (m_fer[p]) begin
                    e_oe[p]  = per_oe[f*16 + p];
                    e_out[p] = per_out[f*16 + p];
                end else begin
                    e_oe[p]  = m_dir[p];
                    e_out[p] = m_dout[p];
                end
            end
            chk("R2 oe", {16'h0, pad_oe & ~m_fer}, {16'h0, e_oe & ~m_fer});
            chk("R2 out", {16'h0, pad_out & ~m_fer}, {16'h0, e_out & ~m_fer});
            chk("R3 oe", {16'h0, pad_oe & m_fer}, {16'h0, e_oe & m_fer});
            chk("R3 out", {16'h0, pad_out & m_fer}, {16'h0, e_out & m_fer});
            chk("R8 R9 irq", {16'h0, irq_pins}, {16'h0, m_s2 & m_inen});
            chk(tag_of(last_ra), bus_rdata, m_rd);
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(int a);
        @(negedge clk);
        bus_ren = 1'b1; bus_addr = 4'(a);
        @(negedge clk);
        bus_ren = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        pad_in = 16'h5A5A;
        repeat (3) @(negedge clk);
        // R1 reset state seen at the ports
        chk("R1 oe", {16'h0, pad_oe}, 32'h0);
        chk("R1 out", {16'h0, pad_out}, 32'h0);
        chk("R1 irq", {16'h0, irq_pins}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) rd(a);             // R1, R10
        wr(9, 32'hFFFF_FFFF); rd(9);                     // R10 unmapped
        wr(5, 32'h0000_00FF); rd(5); rd(6);              // R5
        wr(5, 32'h0); rd(5);                             // R5 zero bits no effect
        wr(3, 32'h0000_0F0F); rd(3);                     // R6
        wr(4, 32'h0000_0003); rd(4);                     // R6
        wr(6, 32'h0000_0011); rd(6);                     // R5
        wr(2, 32'h0000_A5A5); rd(2);                     // R7
        wr(7, 32'h0000_F0F0); rd(7);                     // R8
        pad_in = 16'hFFFF; repeat (3) @(negedge clk); rd(2);  // R7 R8 R9
        pad_in = 16'h0F0F; rd(2);                        // R9 latency window
        wr(1, 32'hE4E4_1B1B); rd(1);                     // R4
        per_out = 64'hDEAD_BEEF_0123_4567;
        per_oe  = 64'h00FF_FF00_F0F0_0F0F;
        wr(0, 32'h0000_0F0F); rd(0);                     // R3
        // R10 same-cycle write and read returns the old value
        @(negedge clk);
        bus_wen = 1'b1; bus_ren = 1'b1; bus_addr = 4'd7; bus_wdata = 32'h0000_1234;
        @(negedge clk);
        bus_wen = 1'b0; bus_ren = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            pad_in    = 16'($urandom);
            per_out   = {$urandom, $urandom};
            per_oe    = {$urandom, $urandom};
            bus_wen   = 1'($urandom);
            bus_ren   = 1'($urandom);
            bus_addr  = 4'($urandom);
            bus_wdata = $urandom;
        end
        @(negedge clk);
        bus_wen = 1'b0; bus_ren = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        #(150000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule